// File: doc/BRIEF.md
# Read Completion Header Generator

This block answers one memory read request with a run of three-doubleword completion headers. Each header comes with the number of payload doublewords that belong to it. The block latches the request when it is accepted: the doubleword address, the length in doublewords, the first and last byte enables, the tag, the requester ID, the traffic class and the attributes. It also latches the completer ID, the completion status and the Read Completion Boundary (RCB) select that are present on the same cycle.

The block splits the transfer only at addresses aligned to the RCB, so every piece ends at the next aligned boundary or at the end of the request. For each piece it fills in the Length, Byte Count and Lower Address fields. Headers leave through a valid/ready handshake, one per transfer. The payload data, the link framing and the integrity fields are produced elsewhere.

A non-successful status gives one header with no data, and that header ends the request. A new request is taken only after the last header of the previous one has been handed off.

Top module: `cplHdrGen`

## Requirements
- R1: While reset is held and on the first cycle after reset, `reqReady` is 1 and `hdrValid` is 0.
- R2: A request is taken on a cycle where `reqValid` and `reqReady` are both 1. From the next cycle `reqReady` stays 0 until the last header of that request has been handed off, and it is 1 on the cycle after that handoff. Request inputs are latched, so changing them after acceptance has no effect.
- R3: While `hdrValid` is 1 and `hdrReady` is 0, all header outputs (`hdrDw0`, `hdrDw1`, `hdrDw2`, `hdrPayDw`, `hdrLast`) hold their values.
- R4: The fixed fields of every header are as follows:
  - `hdrDw0[28:24]` = 01010b.
  - `hdrDw0[30:29]` is the format: 10b with data, 00b without data.
  - `hdrDw0[31]` = 0.
  - `hdrDw0[22:20]` is the request traffic class.
  - `hdrDw0[13:12]` are the request attributes.
  - `hdrDw0[15:14]` = 00.
  - `hdrDw1[31:16]` is the completer ID.
  - `hdrDw1[12]` = 0.
  - `hdrDw2[31:16]` is the requester ID.
  - `hdrDw2[15:8]` is the tag.
  - `hdrDw2[7]` = 0.
- R5: A request length of 0 means 1024 doublewords.
- R6: The RCB is 64 bytes (16 DW) when `rcbSel`=0 and 128 bytes (32 DW) when `rcbSel`=1. Each successful piece runs from the current doubleword address to the next RCB-aligned address or to the end of the request, whichever comes first. Pieces therefore ascend in address and their `hdrPayDw` values sum to the request length.
- R7: The first header's Lower Address (`hdrDw2[6:0]`) is the low 7 bits of (4 × DW address + k). Here k is the index of the lowest set bit of the first byte enable, or 0 if no bit is set. Every later header carries the low 7 bits of its own starting byte address.
- R8: Byte Count (`hdrDw1[11:0]`) on the first header is 4 × length − lead − trail:
  - lead is the k of R7.
  - trail is 3 minus the index of the highest set bit of the last byte enable, or of the first byte enable for a one-DW request, and 0 if that enable is 0000b.
  - Each later header carries the previous count minus the bytes of the previous piece.
  - A count of 4096 is encoded as 0.
- R9: The completion status goes to `hdrDw1[15:13]`; 000b means success. Any other code gives exactly one header, with the following fields:
  - format 00b;
  - length field 0 and `hdrPayDw` 0;
  - `hdrLast` 1;
  - the full initial Byte Count;
  - the Lower Address of R7.
- R10: `hdrLast` is 1 exactly on the final header of a request.
- R11: `hdrPayDw` gives the piece size in DW (1..1024), and `hdrDw0[9:0]` holds it modulo 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Block idle, request can be taken |
| reqDwAddr | input | ADDR_W | Doubleword start address |
| reqLenDw | input | 10 | Length in DW, 0 means 1024 |
| reqFirstBe | input | 4 | Byte enables of the first DW |
| reqLastBe | input | 4 | Byte enables of the last DW |
| reqTag | input | 8 | Request tag |
| reqReqId | input | 16 | Requester ID |
| reqTc | input | 3 | Traffic class |
| reqAttr | input | 2 | Ordering and snoop attributes |
| cplId | input | 16 | Completer ID |
| cplStatus | input | 3 | Completion status code |
| rcbSel | input | 1 | 0: 64-byte RCB, 1: 128-byte RCB |
| hdrValid | output | 1 | Header present |
| hdrReady | input | 1 | Downstream takes header |
| hdrDw0 | output | 32 | Header DW0, byte 0 in bits 31:24 |
| hdrDw1 | output | 32 | Header DW1 |
| hdrDw2 | output | 32 | Header DW2 |
| hdrPayDw | output | 11 | Payload DW count of this header |
| hdrLast | output | 1 | Final header of the request |

## Verification
The first header of a split is where two functions meet. The byte-enable offset moves the Lower Address and trims the Byte Count, and in the same header the RCB split cuts the piece short. A short request can also end exactly on an aligned boundary, so the split decision and the last-enable trim land on the same header. The bench provokes both by sweeping every start offset within a 128-byte window against lengths on either side of 16 and 32 DW, for both RCB sizes, with rotating byte-enable patterns and varying stalls. Each header is judged against an arithmetic walk of the request, and a checker ties each header's count and address to its predecessor's.

// File: rtl/cplHdrGen_pkg.sv
package cplHdrGen_pkg;

  localparam int LEN_W        = 10;
  localparam int CNT_W        = LEN_W + 1;
  localparam int BC_W         = 12;
  localparam int BYTE_W       = BC_W + 1;
  localparam int LA_W         = 7;
  localparam int RCB_SMALL_DW = 16;
  localparam int RCB_LARGE_DW = 32;
  localparam int RCB_OFS_W    = $clog2(RCB_LARGE_DW);

  localparam logic [4:0] CPL_TYPE   = 5'b01010;
  localparam logic [1:0] FMT_NODATA = 2'b00;
  localparam logic [1:0] FMT_DATA   = 2'b10;
  localparam logic [2:0] STAT_OK    = 3'b000;

  typedef struct packed {
    logic load;
    logic advance;
  } ctrlStrobe_t;

  typedef enum logic {S_IDLE, S_EMIT} genState_t;

  // bytes below the lowest enabled lane
  function automatic logic [1:0] leadGap(input logic [3:0] be);
    logic [1:0] gap;
    gap = 2'd0;
    for (int i = 3; i >= 0; i--) begin
      if (be[i]) gap = 2'(i);
    end
    return gap;
  endfunction

  // bytes above the highest enabled lane
  function automatic logic [1:0] trailGap(input logic [3:0] be);
    logic [1:0] gap;
    gap = 2'd0;
    for (int i = 0; i < 4; i++) begin
      if (be[i]) gap = 2'(3 - i);
    end
    return gap;
  endfunction

endpackage

// File: rtl/cplHdrGen_ctrl.sv
module cplHdrGen_ctrl
  import cplHdrGen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        hdrReady,
  input  logic        pieceLast,
  output logic        reqReady,
  output logic        hdrValid,
  output ctrlStrobe_t strobe
);

  genState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          stateNext   = S_EMIT;
        end
      end
      S_EMIT: begin
        if (hdrReady) begin
          if (pieceLast) stateNext = S_IDLE;
          else           strobe.advance = 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign reqReady = (state == S_IDLE);
  assign hdrValid = (state == S_EMIT);

endmodule

// File: rtl/cplHdrGen_dp.sv
module cplHdrGen_dp
  import cplHdrGen_pkg::*;
#(
  parameter int ADDR_W = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqDwAddr,
  input  logic [LEN_W-1:0]  reqLenDw,
  input  logic [3:0]        reqFirstBe,
  input  logic [3:0]        reqLastBe,
  input  logic [7:0]        reqTag,
  input  logic [15:0]       reqReqId,
  input  logic [2:0]        reqTc,
  input  logic [1:0]        reqAttr,
  input  logic [15:0]       cplId,
  input  logic [2:0]        cplStatus,
  input  logic              rcbSel,
  output logic [31:0]       hdrDw0,
  output logic [31:0]       hdrDw1,
  output logic [31:0]       hdrDw2,
  output logic [CNT_W-1:0]  hdrPayDw,
  output logic              pieceLast
);

  // latched request state
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remDw;
  logic [BYTE_W-1:0] remBytes;
  logic [1:0]        leadR;
  logic              isFirst;
  logic [7:0]        tagR;
  logic [15:0]       reqIdR;
  logic [15:0]       cplIdR;
  logic [2:0]        tcR;
  logic [1:0]        attrR;
  logic [2:0]        statusR;
  logic              rcbR;

  // load-time arithmetic
  logic [CNT_W-1:0]  lenEff;
  logic [1:0]        trailSel;
  logic [BYTE_W-1:0] totalBytes;

  always_comb begin
    lenEff     = (reqLenDw == '0) ? (CNT_W'(1) << LEN_W) : {1'b0, reqLenDw};
    trailSel   = (lenEff == CNT_W'(1)) ? trailGap(reqFirstBe) : trailGap(reqLastBe);
    totalBytes = {lenEff, 2'b00} - BYTE_W'(leadGap(reqFirstBe)) - BYTE_W'(trailSel);
  end

  // per-piece arithmetic
  logic [CNT_W-1:0]     rcbDw;
  logic [RCB_OFS_W-1:0] ofsInRcb;
  logic [CNT_W-1:0]     room;
  logic                 fits;
  logic                 isErr;
  logic [CNT_W-1:0]     payDw;
  logic [1:0]           firstSkip;
  logic [LA_W-1:0]      lowAddr;
  logic [BYTE_W-1:0]    pieceBytes;

  always_comb begin
    rcbDw      = rcbR ? CNT_W'(RCB_LARGE_DW) : CNT_W'(RCB_SMALL_DW);
    ofsInRcb   = rcbR ? curAddr[RCB_OFS_W-1:0] : {1'b0, curAddr[RCB_OFS_W-2:0]};
    room       = rcbDw - CNT_W'(ofsInRcb);
    fits       = (remDw <= room);
    isErr      = (statusR != STAT_OK);
    payDw      = isErr ? '0 : (fits ? remDw : room);
    pieceLast  = isErr || fits;
    firstSkip  = isFirst ? leadR : 2'd0;
    lowAddr    = {curAddr[LA_W-3:0], 2'b00} + LA_W'(firstSkip);
    pieceBytes = {payDw, 2'b00} - BYTE_W'(firstSkip);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      remDw    <= '0;
      remBytes <= '0;
      leadR    <= '0;
      isFirst  <= 1'b0;
      tagR     <= '0;
      reqIdR   <= '0;
      cplIdR   <= '0;
      tcR      <= '0;
      attrR    <= '0;
      statusR  <= '0;
      rcbR     <= 1'b0;
    end else if (strobe.load) begin
      curAddr  <= reqDwAddr;
      remDw    <= lenEff;
      remBytes <= totalBytes;
      leadR    <= leadGap(reqFirstBe);
      isFirst  <= 1'b1;
      tagR     <= reqTag;
      reqIdR   <= reqReqId;
      cplIdR   <= cplId;
      tcR      <= reqTc;
      attrR    <= reqAttr;
      statusR  <= cplStatus;
      rcbR     <= rcbSel;
    end else if (strobe.advance) begin
      curAddr  <= curAddr + ADDR_W'(payDw);
      remDw    <= remDw - payDw;
      remBytes <= remBytes - pieceBytes;
      isFirst  <= 1'b0;
    end
  end

  assign hdrDw0 = {1'b0, (isErr ? FMT_NODATA : FMT_DATA), CPL_TYPE,
                   1'b0, tcR, 4'b0000,
                   1'b0, 1'b0, attrR, 2'b00, payDw[LEN_W-1:0]};
  assign hdrDw1 = {cplIdR, statusR, 1'b0, remBytes[BC_W-1:0]};
  assign hdrDw2 = {reqIdR, tagR, 1'b0, lowAddr};
  assign hdrPayDw = payDw;

endmodule

// File: rtl/cplHdrGen.sv
module cplHdrGen
  import cplHdrGen_pkg::*;
#(
  parameter int ADDR_W = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqDwAddr,
  input  logic [9:0]        reqLenDw,
  input  logic [3:0]        reqFirstBe,
  input  logic [3:0]        reqLastBe,
  input  logic [7:0]        reqTag,
  input  logic [15:0]       reqReqId,
  input  logic [2:0]        reqTc,
  input  logic [1:0]        reqAttr,
  input  logic [15:0]       cplId,
  input  logic [2:0]        cplStatus,
  input  logic              rcbSel,
  output logic              hdrValid,
  input  logic              hdrReady,
  output logic [31:0]       hdrDw0,
  output logic [31:0]       hdrDw1,
  output logic [31:0]       hdrDw2,
  output logic [10:0]       hdrPayDw,
  output logic              hdrLast
);

  ctrlStrobe_t strobe;
  logic        pieceLast;

  cplHdrGen_ctrl ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .hdrReady  (hdrReady),
    .pieceLast (pieceLast),
    .reqReady  (reqReady),
    .hdrValid  (hdrValid),
    .strobe    (strobe)
  );

  cplHdrGen_dp #(.ADDR_W(ADDR_W)) dpInst (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqDwAddr  (reqDwAddr),
    .reqLenDw   (reqLenDw),
    .reqFirstBe (reqFirstBe),
    .reqLastBe  (reqLastBe),
    .reqTag     (reqTag),
    .reqReqId   (reqReqId),
    .reqTc      (reqTc),
    .reqAttr    (reqAttr),
    .cplId      (cplId),
    .cplStatus  (cplStatus),
    .rcbSel     (rcbSel),
    .hdrDw0     (hdrDw0),
    .hdrDw1     (hdrDw1),
    .hdrDw2     (hdrDw2),
    .hdrPayDw   (hdrPayDw),
    .pieceLast  (pieceLast)
  );

  assign hdrLast = hdrValid && pieceLast;

endmodule

// File: rtl/cplHdrGen_chk.sv
module cplHdrGen_chk
  import cplHdrGen_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             rcbSel,
  input logic             hdrValid,
  input logic             hdrReady,
  input logic             hdrLast,
  input logic [31:0]      hdrDw0,
  input logic [31:0]      hdrDw1,
  input logic [31:0]      hdrDw2,
  input logic [CNT_W-1:0] hdrPayDw
);

  logic            rcbLat;
  logic            chainPend;
  logic [BC_W-1:0] expBc;
  logic [LA_W-1:0] expLa;
  logic            handoff;
  logic [CNT_W:0]  endOfs;

  assign handoff = hdrValid && hdrReady;
  assign endOfs  = rcbLat ? ((CNT_W+1)'(hdrDw2[6:2]) + (CNT_W+1)'(hdrPayDw))
                          : ((CNT_W+1)'(hdrDw2[5:2]) + (CNT_W+1)'(hdrPayDw));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rcbLat    <= 1'b0;
      chainPend <= 1'b0;
      expBc     <= '0;
      expLa     <= '0;
    end else begin
      if (reqValid && reqReady) rcbLat <= rcbSel;
      if (handoff) begin
        chainPend <= !hdrLast;
        expBc     <= hdrDw1[BC_W-1:0] - (BC_W'({hdrPayDw, 2'b00}) - BC_W'(hdrDw2[1:0]));
        expLa     <= {hdrDw2[6:2], 2'b00} + LA_W'({hdrPayDw, 2'b00});
      end
    end
  end

  // R3: stalled header holds
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && !hdrReady |=> hdrValid && $stable(hdrDw0) && $stable(hdrDw1)
                              && $stable(hdrDw2) && $stable(hdrPayDw) && $stable(hdrLast));

  // R2: no acceptance while headers are pending
  assert_no_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |-> !reqReady);

  // R9: error status is a single dataless header
  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && (hdrDw1[15:13] != 3'b000) |->
      hdrLast && (hdrPayDw == '0) && (hdrDw0[30:29] == 2'b00));

  // R6: no piece crosses an aligned boundary
  assert_rcb_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid && (hdrPayDw != '0) |-> endOfs <= (rcbLat ? (CNT_W+1)'(32) : (CNT_W+1)'(16)));

  // R8 and R7: each follow-on header continues from its predecessor
  assert_chain_R8: assert property (@(posedge clk) disable iff (!rstN)
    chainPend && hdrValid |-> (hdrDw1[BC_W-1:0] == expBc) && (hdrDw2[6:0] == expLa));

endmodule

bind cplHdrGen cplHdrGen_chk chkInst (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rcbSel   (rcbSel),
  .hdrValid (hdrValid),
  .hdrReady (hdrReady),
  .hdrLast  (hdrLast),
  .hdrDw0   (hdrDw0),
  .hdrDw1   (hdrDw1),
  .hdrDw2   (hdrDw2),
  .hdrPayDw (hdrPayDw)
);

// File: tb/cplHdrGen_test.sv
`timescale 1ns/1ps
module cplHdrGen_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [29:0] reqDwAddr = '0;
  logic [9:0]  reqLenDw = '0;
  logic [3:0]  reqFirstBe = '0;
  logic [3:0]  reqLastBe = '0;
  logic [7:0]  reqTag = '0;
  logic [15:0] reqReqId = '0;
  logic [2:0]  reqTc = '0;
  logic [1:0]  reqAttr = '0;
  logic [15:0] cplId = '0;
  logic [2:0]  cplStatus = '0;
  logic        rcbSel = 1'b0;
  logic        hdrValid;
  logic        hdrReady = 1'b0;
  logic [31:0] hdrDw0, hdrDw1, hdrDw2;
  logic [10:0] hdrPayDw;
  logic        hdrLast;

  int checks = 0;
  int fails  = 0;
  int reqNum = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cplHdrGen uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqDwAddr(reqDwAddr), .reqLenDw(reqLenDw), .reqFirstBe(reqFirstBe),
    .reqLastBe(reqLastBe), .reqTag(reqTag), .reqReqId(reqReqId), .reqTc(reqTc),
    .reqAttr(reqAttr), .cplId(cplId), .cplStatus(cplStatus), .rcbSel(rcbSel),
    .hdrValid(hdrValid), .hdrReady(hdrReady), .hdrDw0(hdrDw0), .hdrDw1(hdrDw1),
    .hdrDw2(hdrDw2), .hdrPayDw(hdrPayDw), .hdrLast(hdrLast)
  );

  task automatic chk(input string tagName, input string what,
                     input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tagName, what, act, exp);
    end
  endtask

  function automatic int leadB(input logic [3:0] be);
    int g = 0;
    for (int i = 3; i >= 0; i--) if (be[i]) g = i;
    return g;
  endfunction

  function automatic int trailB(input logic [3:0] be);
    int g = 0;
    for (int i = 0; i < 4; i++) if (be[i]) g = 3 - i;
    return g;
  endfunction

  task automatic runReq(input int addr, input int len, input logic [3:0] fbe,
                        input logic [3:0] lbe, input bit rcb, input logic [2:0] st,
                        input int stallSeed);
    logic [2:0]  tc;
    logic [1:0]  attr;
    logic [7:0]  tag;
    logic [15:0] rid, cid;
    int lenEff, ld, tr, remB, remDw, cur, piece;
    bit first, lastP;
    string lenTag;
    reqNum++;
    tc   = 3'(reqNum);
    attr = 2'(reqNum >> 1);
    tag  = 8'(reqNum * 7);
    rid  = 16'(reqNum * 13 + 256);
    cid  = 16'(49152 + reqNum);
    reqDwAddr = 30'(addr); reqLenDw = 10'(len); reqFirstBe = fbe; reqLastBe = lbe;
    reqTag = tag; reqReqId = rid; reqTc = tc; reqAttr = attr; cplId = cid;
    cplStatus = st; rcbSel = rcb;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    // scramble inputs: the latched copy must be used (R2)
    reqDwAddr = ~reqDwAddr; reqLenDw = ~reqLenDw; reqFirstBe = ~fbe; reqLastBe = ~lbe;
    reqTag = ~tag; reqReqId = ~rid; reqTc = ~tc; reqAttr = ~attr; cplId = ~cid;
    cplStatus = ~st; rcbSel = ~rcb;
    chk("R2", "ready after accept", 96'(reqReady), 96'(0));

    lenEff = (len == 0) ? 1024 : len;
    lenTag = (len == 0) ? "R5 " : "";
    ld = leadB(fbe);
    tr = (lenEff == 1) ? trailB(fbe) : trailB(lbe);
    remB = 4 * lenEff - ld - tr;
    remDw = lenEff; cur = addr; first = 1'b1; lastP = 1'b0; piece = 0;
    while (!lastP) begin
      int rcbDw, room, pay, skip, la, stalls;
      logic [31:0] e0, e1, e2;
      rcbDw = rcb ? 32 : 16;
      room  = rcbDw - (cur % rcbDw);
      skip  = first ? ld : 0;
      if (st != 3'b000) begin pay = 0; lastP = 1'b1; end
      else begin pay = (remDw < room) ? remDw : room; lastP = (pay == remDw); end
      la = (cur * 4 + skip) % 128;
      e0 = {1'b0, (st != 3'b000) ? 2'b00 : 2'b10, 5'b01010, 1'b0, tc, 4'b0000,
            2'b00, attr, 2'b00, 10'(pay)};
      e1 = {cid, st, 1'b0, 12'(remB)};
      e2 = {rid, tag, 1'b0, 7'(la)};
      chk("R2", "header present", 96'(hdrValid), 96'(1));
      chk({lenTag, "R4 R11"}, "dw0", 96'(hdrDw0), 96'(e0));
      chk({lenTag, "R8 R9"}, "dw1", 96'(hdrDw1), 96'(e1));
      chk("R7", "dw2", 96'(hdrDw2), 96'(e2));
      chk({lenTag, "R6"}, "payload dw", 96'(hdrPayDw), 96'(pay));
      chk("R10", "last flag", 96'(hdrLast), 96'(lastP));
      stalls = (stallSeed + piece) % 3;
      for (int s = 0; s < stalls; s++) begin
        @(negedge clk);
        chk("R3", "held header", {hdrDw0, hdrDw1, hdrDw2}, {e0, e1, e2});
      end
      hdrReady = 1'b1;
      @(negedge clk);
      hdrReady = 1'b0;
      remB  = remB - (pay * 4 - skip);
      remDw = remDw - pay;
      cur   = cur + pay;
      first = 1'b0;
      piece++;
    end
    chk("R10", "no header after last", 96'(hdrValid), 96'(0));
    chk("R2", "ready after last handoff", 96'(reqReady), 96'(1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lens[9] = '{1, 2, 5, 15, 16, 17, 32, 33, 47};
    logic [3:0] fbes[4] = '{4'hF, 4'hE, 4'hC, 4'h8};
    logic [3:0] lbes[4] = '{4'hF, 4'h7, 4'h3, 4'h1};
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", 96'(reqReady), 96'(1));
    chk("R1", "valid in reset", 96'(hdrValid), 96'(0));
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", 96'(reqReady), 96'(1));
    chk("R1", "valid after reset", 96'(hdrValid), 96'(0));

    // R6 R7 R8: sweep start offset, length and RCB size
    for (int r = 0; r < 2; r++)
      for (int a = 0; a < 36; a++)
        for (int li = 0; li < 9; li++)
          runReq(a + 64 * li, lens[li], fbes[(a + li) % 4], lbes[(a / 4 + li) % 4],
                 r[0], 3'b000, a + li);

    // R5: zero length is 1024 DW, byte count 4096 encodes as 0
    runReq(0, 0, 4'hF, 4'hF, 1'b0, 3'b000, 1);
    runReq(7, 0, 4'hE, 4'h7, 1'b1, 3'b000, 2);
    // R8: one-DW requests with sparse and empty enables
    runReq(9, 1, 4'b0110, 4'h0, 1'b0, 3'b000, 0);
    runReq(9, 1, 4'b0000, 4'hF, 1'b1, 3'b000, 1);
    runReq(15, 2, 4'b0000, 4'b0000, 1'b0, 3'b000, 2);
    // R9: non-success codes
    runReq(3, 20, 4'hC, 4'h3, 1'b0, 3'b001, 0);
    runReq(5, 40, 4'h8, 4'hF, 1'b1, 3'b010, 1);
    runReq(30, 0, 4'hE, 4'h1, 1'b0, 3'b100, 2);
    runReq(12, 3, 4'hF, 4'hF, 1'b1, 3'b011, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule